// File: doc/BRIEF.md
# Mailbox-Driven Bit-Flip Fault Injector

This block lets software running on a processor inject single-bit faults into protected storage. The processor and the controller share one 32-bit word in memory. Software writes a command into that word. The controller reads it through the `mbox_word` port and, for a fault command, raises a one-cycle flip strobe towards one of nine storage targets. The strobe carries the bit number and the word or entry number to corrupt. The controller then acknowledges by writing zero to the word through `mbox_clr`. Software polls the word until it reads zero, so only one command is in flight at any time.

A command word has three fields: the code in bits 31:24, the bit number in bits 23:16 and the word or entry number in bits 15:0. Fault commands are only honoured after the start word has been seen. Two further codes switch a debug-reporting flag on and off.

The controller is a five-state machine:
- `ST_IDLE` leaves for `ST_DECODE` when it sees a non-zero word, which it captures.
- `ST_DECODE` updates the mode flags and goes to `ST_FLIP` for an armed fault command, or to `ST_ACK` for any other command.
- `ST_FLIP` drives the strobe and always goes to `ST_ACK`.
- `ST_ACK` drives the clear and always goes to `ST_DRAIN`.
- `ST_DRAIN` returns to `ST_IDLE` once the word reads zero.

Top module: `fi_mailbox_ctrl`

## Requirements
- R1: After reset, `flip_sel` is all zero, `mbox_clr` is low, and `armed`, `debug_en` and `cmd_err` are all low.
- R2: While the shared word reads zero, no strobe and no clear is produced.
- R3: The exact word 0x88000000 sets `armed`. It is acknowledged with one clear and produces no strobe.
- R4: A fault code (1 to 9) received while `armed` is low is acknowledged, produces no strobe and leaves `cmd_err` unchanged. A reset clears `armed` again.
- R5: Once armed, fault code k raises `flip_sel` bit k-1 alone, for exactly one cycle, with `flip_bit` equal to word bits 23:16 and `flip_idx` equal to word bits 15:0. The targets by code are:
  - 1: instruction cache data.
  - 2: instruction cache tag.
  - 3: data cache data.
  - 4: data cache tag.
  - 5: data MMU match.
  - 6: data MMU translate.
  - 7: instruction MMU match.
  - 8: instruction MMU translate.
  - 9: register file.
- R6: Code 0xFF sets `debug_en` and code 0xFE clears it. Both are acknowledged and produce no strobe.
- R7: Any other non-zero word is acknowledged, produces no strobe, and sets `cmd_err`. This includes code 0, codes 0x0A to 0xFD, and code 0x88 with non-zero low bits. `cmd_err` then stays set until reset.
- R8: Every command gets exactly one single-cycle `mbox_clr`. For a fault command, the clear comes in the cycle right after the strobe.
- R9: A command is acted on once, even while the word still holds it. A new command written in the first cycle the word reads zero after a clear is picked up and executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mbox_word | input | 32 | Current content of the shared command word |
| mbox_clr | output | 1 | One-cycle request to write zero to the shared word |
| flip_sel | output | 9 | One-hot flip strobe; bit k-1 targets code k |
| flip_bit | output | 8 | Bit number to invert, valid with the strobe |
| flip_idx | output | 16 | Word or entry number, valid with the strobe |
| armed | output | 1 | Start word has been seen |
| debug_en | output | 1 | Debug reporting flag |
| cmd_err | output | 1 | Sticky flag for an undefined command |

## Verification
The two functions that can fall in the same cycle are the clear of one command and the arrival of the next. The cycle in which the word first reads zero after a clear is also the cycle in which software may write again. The bench provokes this by issuing every table command in exactly that cycle. It judges the outcome by requiring, for each command, exactly one strobe with the expected target and fields, exactly one clear one cycle after that strobe, and the word back at zero.

// File: rtl/fi_pkg.sv
package fi_pkg;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_START   = 8'h88;
    localparam logic [CODE_W-1:0] CODE_DBG_ON  = 8'hFF;
    localparam logic [CODE_W-1:0] CODE_DBG_OFF = 8'hFE;

    typedef enum logic [2:0] {
        K_START,
        K_DBG_ON,
        K_DBG_OFF,
        K_FAULT,
        K_SKIP,
        K_BAD
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_FLIP,
        ST_ACK,
        ST_DRAIN
    } fsm_state_e;
endpackage

// File: rtl/fi_cmd_decode.sv
module fi_cmd_decode
    import fi_pkg::*;
#(
    parameter int BIT_W   = 8,
    parameter int IDX_W   = 16,
    parameter int NUM_TGT = 9
) (
    input  logic [CODE_W+BIT_W+IDX_W-1:0] cmd,
    input  logic                          armed,
    output cmd_kind_e                     kind,
    output logic [CODE_W-1:0]             code,
    output logic [BIT_W-1:0]              bit_no,
    output logic [IDX_W-1:0]              idx_no
);
    localparam int LOW_W = BIT_W + IDX_W;

    logic is_target;

    always_comb begin
        code      = cmd[LOW_W +: CODE_W];
        bit_no    = cmd[IDX_W +: BIT_W];
        idx_no    = cmd[IDX_W-1:0];
        is_target = (code != '0) && (code <= CODE_W'(NUM_TGT));
        if ((code == CODE_START) && (cmd[LOW_W-1:0] == '0))
            kind = K_START;
        else if (code == CODE_DBG_ON)
            kind = K_DBG_ON;
        else if (code == CODE_DBG_OFF)
            kind = K_DBG_OFF;
        else if (is_target)
            kind = armed ? K_FAULT : K_SKIP;
        else
            kind = K_BAD;
    end
endmodule

// File: rtl/fi_mode_regs.sv
module fi_mode_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic set_start,
    input  logic set_dbg,
    input  logic clr_dbg,
    input  logic set_err,
    output logic armed,
    output logic debug_en,
    output logic cmd_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            debug_en <= 1'b0;
            cmd_err  <= 1'b0;
        end else begin
            if (set_start) armed <= 1'b1;
            if (set_dbg)
                debug_en <= 1'b1;
            else if (clr_dbg)
                debug_en <= 1'b0;
            if (set_err) cmd_err <= 1'b1;
        end
    end

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    p_armed_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
endmodule

// File: rtl/fi_flip_driver.sv
module fi_flip_driver
    import fi_pkg::*;
#(
    parameter int BIT_W   = 8,
    parameter int IDX_W   = 16,
    parameter int NUM_TGT = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [CODE_W-1:0]  code,
    input  logic [BIT_W-1:0]   bit_no,
    input  logic [IDX_W-1:0]   idx_no,
    output logic [NUM_TGT-1:0] flip_sel,
    output logic [BIT_W-1:0]   flip_bit,
    output logic [IDX_W-1:0]   flip_idx
);
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        assign flip_sel[g] = fire && (code == CODE_W'(g + 1));
    end

    assign flip_bit = fire ? bit_no : '0;
    assign flip_idx = fire ? idx_no : '0;

    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip_sel));

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_sel != '0) |=> (flip_sel == '0));
endmodule

// File: rtl/fi_mailbox_ctrl.sv
module fi_mailbox_ctrl
    import fi_pkg::*;
#(
    parameter int BIT_W   = 8,
    parameter int IDX_W   = 16,
    parameter int NUM_TGT = 9
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [CODE_W+BIT_W+IDX_W-1:0]     mbox_word,
    output logic                              mbox_clr,
    output logic [NUM_TGT-1:0]                flip_sel,
    output logic [BIT_W-1:0]                  flip_bit,
    output logic [IDX_W-1:0]                  flip_idx,
    output logic                              armed,
    output logic                              debug_en,
    output logic                              cmd_err
);
    localparam int WORD_W = CODE_W + BIT_W + IDX_W;

    fsm_state_e         state, state_nx;
    logic [WORD_W-1:0]  cmd_q;
    cmd_kind_e          kind;
    logic [CODE_W-1:0]  code;
    logic [BIT_W-1:0]   bit_no;
    logic [IDX_W-1:0]   idx_no;
    logic               upd, fire;

    // State register and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cmd_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && mbox_word != '0)
                cmd_q <= mbox_word;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (mbox_word != '0) state_nx = ST_DECODE;
            ST_DECODE: state_nx = (kind == K_FAULT) ? ST_FLIP : ST_ACK;
            ST_FLIP:   state_nx = ST_ACK;
            ST_ACK:    state_nx = ST_DRAIN;
            ST_DRAIN:  if (mbox_word == '0) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        upd      = 1'b0;
        fire     = 1'b0;
        mbox_clr = 1'b0;
        unique case (state)
            ST_DECODE: upd      = 1'b1;
            ST_FLIP:   fire     = 1'b1;
            ST_ACK:    mbox_clr = 1'b1;
            default: ;
        endcase
    end

    fi_cmd_decode #(.BIT_W(BIT_W), .IDX_W(IDX_W), .NUM_TGT(NUM_TGT)) u_dec (
        .cmd    (cmd_q),
        .armed  (armed),
        .kind   (kind),
        .code   (code),
        .bit_no (bit_no),
        .idx_no (idx_no)
    );

    fi_mode_regs u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_start (upd && kind == K_START),
        .set_dbg   (upd && kind == K_DBG_ON),
        .clr_dbg   (upd && kind == K_DBG_OFF),
        .set_err   (upd && kind == K_BAD),
        .armed     (armed),
        .debug_en  (debug_en),
        .cmd_err   (cmd_err)
    );

    fi_flip_driver #(.BIT_W(BIT_W), .IDX_W(IDX_W), .NUM_TGT(NUM_TGT)) u_flip (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .code     (code),
        .bit_no   (bit_no),
        .idx_no   (idx_no),
        .flip_sel (flip_sel),
        .flip_bit (flip_bit),
        .flip_idx (flip_idx)
    );

    p_ack_after_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_sel != '0) |=> mbox_clr);

    p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_clr |=> !mbox_clr);

    p_flip_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_sel != '0) |-> armed);

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && mbox_word == '0) |=> (!mbox_clr && flip_sel == '0));
endmodule

// File: tb/fi_mailbox_ctrl_test.sv
module fi_mailbox_ctrl_test;
    localparam int NV = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mbox;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_data = '0;
    logic        mbox_clr;
    logic [8:0]  flip_sel;
    logic [7:0]  flip_bit;
    logic [15:0] flip_idx;
    logic        armed, debug_en, cmd_err;

    int checks = 0;
    int errors = 0;

    // strobe/ack observations of the last command
    int          n_strobe, n_ack, cyc_strobe, cyc_ack;
    logic [8:0]  seen_sel;
    logic [7:0]  seen_bit;
    logic [15:0] seen_idx;
    logic        drained;

    always #2 clk = ~clk;

    // shared memory word: controller clear wins over a processor write
    always @(posedge clk) begin
        if (!rst_n)        mbox <= '0;
        else if (mbox_clr) mbox <= '0;
        else if (cpu_wr)   mbox <= cpu_data;
    end

    fi_mailbox_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mbox_word(mbox), .mbox_clr(mbox_clr),
        .flip_sel(flip_sel), .flip_bit(flip_bit), .flip_idx(flip_idx),
        .armed(armed), .debug_en(debug_en), .cmd_err(cmd_err)
    );

    localparam logic [31:0] TV_WORD [0:NV-1] = '{
        32'h0305_0012, 32'hFF00_0000, 32'h8800_0000,
        32'h011F_0040, 32'h0200_FFFF, 32'h0307_0003, 32'h0417_0100,
        32'h050F_0007, 32'h0610_00A5, 32'h0708_0000, 32'h08FF_1234,
        32'h091F_001F, 32'hFE00_0000, 32'h0A00_0001, 32'h0100_0000,
        32'h8800_0001, 32'h00FF_0000
    };
    localparam logic [8:0] TV_SEL [0:NV-1] = '{
        9'h000, 9'h000, 9'h000,
        9'h001, 9'h002, 9'h004, 9'h008, 9'h010, 9'h020, 9'h040, 9'h080,
        9'h100, 9'h000, 9'h000, 9'h001, 9'h000, 9'h000
    };
    // {armed, debug_en, cmd_err} after the command
    localparam logic [2:0] TV_FLAGS [0:NV-1] = '{
        3'b000, 3'b010, 3'b110,
        3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110,
        3'b110, 3'b100, 3'b101, 3'b101, 3'b101, 3'b101
    };

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // write a command at a falling edge and watch until it is acknowledged and drained
    task automatic issue(input logic [31:0] w);
        cpu_data = w;
        cpu_wr   = 1'b1;
        n_strobe = 0; n_ack = 0; cyc_strobe = -1; cyc_ack = -1;
        seen_sel = '0; seen_bit = '0; seen_idx = '0; drained = 1'b0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            cpu_wr = 1'b0;
            if (flip_sel != '0) begin
                n_strobe++;
                cyc_strobe = c;
                seen_sel = flip_sel; seen_bit = flip_bit; seen_idx = flip_idx;
            end
            if (mbox_clr) begin
                n_ack++;
                cyc_ack = c;
            end
            if (n_ack > 0 && !mbox_clr && mbox == '0) begin
                drained = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(flip_sel == '0, "R1", "flip_sel", 32'(flip_sel), 0);
        chk(!mbox_clr, "R1", "mbox_clr", 32'(mbox_clr), 0);
        chk({armed, debug_en, cmd_err} == 3'b000, "R1", "flags",
            32'({armed, debug_en, cmd_err}), 0);
        rst_n = 1'b1;

        // R2 zero word stays idle
        begin
            int bad = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (flip_sel != '0 || mbox_clr) bad++;
            end
            chk(bad == 0, "R2", "activity on zero word", 32'(bad), 0);
        end

        // table walk, each command issued in the first cycle the word reads zero (R9)
        for (int v = 0; v < NV; v++) begin
            issue(TV_WORD[v]);
            chk(n_strobe == (TV_SEL[v] != '0 ? 1 : 0), "R5", "strobe count",
                32'(n_strobe), 32'(TV_SEL[v] != '0));
            chk(seen_sel == TV_SEL[v], "R5", "target", 32'(seen_sel), 32'(TV_SEL[v]));
            if (TV_SEL[v] != '0) begin
                chk(seen_bit == TV_WORD[v][23:16], "R5", "bit", 32'(seen_bit),
                    32'(TV_WORD[v][23:16]));
                chk(seen_idx == TV_WORD[v][15:0], "R5", "index", 32'(seen_idx),
                    32'(TV_WORD[v][15:0]));
                chk(cyc_ack == cyc_strobe + 1, "R8", "ack after strobe",
                    32'(cyc_ack), 32'(cyc_strobe + 1));
            end
            chk(n_ack == 1, "R8", "ack count", 32'(n_ack), 1);
            chk(drained, "R9", "word drained", 32'(mbox), 0);
            chk({armed, debug_en, cmd_err} == TV_FLAGS[v], "R3 R4 R6 R7", "flags",
                32'({armed, debug_en, cmd_err}), 32'(TV_FLAGS[v]));
        end

        // R9 word held unchanged after drain: no re-execution
        begin
            int bad = 0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (flip_sel != '0 || mbox_clr) bad++;
            end
            chk(bad == 0, "R9", "repeat activity", 32'(bad), 0);
        end

        // R1/R4 reset clears flags; fault after reset is not honoured
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk({armed, debug_en, cmd_err} == 3'b000, "R1", "flags after reset",
            32'({armed, debug_en, cmd_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(32'h0902_0005);
        chk(n_strobe == 0, "R4", "strobe while disarmed", 32'(n_strobe), 0);
        chk(n_ack == 1, "R4", "ack while disarmed", 32'(n_ack), 1);
        chk(!cmd_err, "R4", "cmd_err untouched", 32'(cmd_err), 0);

        // R3 start re-arms; R5 register-file target at boundary bit/index
        issue(32'h8800_0000);
        chk(armed && n_strobe == 0, "R3", "rearm", 32'(armed), 1);
        issue(32'h09FF_FFFF);
        chk(seen_sel == 9'h100 && seen_bit == 8'hFF && seen_idx == 16'hFFFF,
            "R5", "boundary fields", {7'd0, seen_sel, seen_idx}, {7'd0, 9'h100, 16'hFFFF});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule